// File: doc/BRIEF.md
# DRAM Manual Command Issuer

This block lets software place single housekeeping commands on the pins of a DDR SDRAM channel with up to four ranks. Software stores the mode and extended-mode values in a mode store. It then writes a command word that names an operation and a set of target ranks. For each accepted command word the block drives exactly one command cycle on the chip-select, RAS, CAS, WE, bank-address and address pins. It also keeps a clock-enable level for each rank, which records whether the rank is in self-refresh or power-down.

The operations are: loading the mode register and the extended mode register, precharging all banks, auto refresh, and entering or leaving self-refresh or power-down. Each issued command starts a programmable busy window. A command word written during that window is held back and issued when the window has elapsed, so consecutive commands always have a minimum spacing. When the optional FCRAM setting is on, two extra high address bits are driven during mode loads.

Top module: `dram_cmd_issuer`

## Requirements
- R1: After reset all chip selects and RAS/CAS/WE are high, bank address and address are zero, all four clock enables are high and `busy` is low.
- R2: The command word carries the operation code in bits 3:0 and the rank mask in bits 7:4, where bit 4+i selects rank i. Every selected rank sees its chip select low in the same cycle, and the pins change in the cycle after the write. An empty mask gives a cycle with no chip select low.
- R3: Code 1 (mode load) drives selected CS, RAS, CAS and WE low, bank address 00 and the mode value on address 12:0. Code 0 (extended mode load) does the same with bank address 01 and the extended value.
- R4: The mode store holds the mode value in bits 12:0 with its high bits in 14:13, and the extended value in bits 28:16 with its high bits in 30:29. After reset the mode value is 0x22 and all other fields are zero.
- R5: When `fcram_en` is high, a mode or extended mode load drives the matching two high bits on address 14:13. When it is low, address 14:13 is zero.
- R6: Code 2 (precharge all) drives RAS and WE low, CAS high and address 0x400 (only bit 10 set). The bank address keeps its previous value.
- R7: Code 3 (auto refresh) drives RAS and CAS low and WE high, and leaves the clock enables unchanged.
- R8: Code 4 drives the auto refresh pattern and in the same cycle takes the clock enable of each selected rank low. Code 5 drives no chip select and raises the clock enable of each selected rank.
- R9: Code 6 takes the clock enable of each selected rank low and code 7 raises it. Both drive no chip select.
- R10: Outside a command cycle all chip selects and RAS/CAS/WE are high, and address, bank address and clock enables keep their values.
- R11: `busy` is high for exactly `gap_cycles` cycles, starting with the command cycle.
- R12: A command written while `busy` is high is issued in the cycle after `busy` falls, that is `gap_cycles`+1 cycles after the previous command cycle. If several are written during one window, only the last one is issued.
- R13: Codes 8 to 15 are ignored. They drive no command cycle, start no busy window and change no clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Write strobe for the mode store |
| mode_wdata | input | 32 | Mode store write data |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_word | input | 8 | Operation code and rank mask |
| fcram_en | input | 1 | Drive the extra high address bits during mode loads |
| gap_cycles | input | 8 | Length of the busy window after each command |
| dram_cs_n | output | 4 | Chip selects, active low, one per rank |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | 2 | Bank address |
| dram_addr | output | 15 | Address lines |
| dram_cke | output | 4 | Clock enables, one per rank |
| busy | output | 1 | Command spacing window active |

## Verification
An accepted command word reaches the pins one cycle after the write, and `busy` rises in that same cycle. A command held back during a window appears `gap_cycles`+1 cycles after the command that opened the window. The driver stamps every expected pin pattern and every busy level with the absolute cycle in which it is due. The monitor compares that entry at exactly that cycle, and in every cycle with no entry it requires the idle pattern with the last address, bank and clock-enable values. This catches commands that come early, late, twice, or not at all.

// File: rtl/dci_pkg.sv
`timescale 1ns/1ps
package dci_pkg;
    localparam int RANKS      = 4;
    localparam int CODE_W     = 4;
    localparam int WORD_W     = CODE_W + RANKS;
    localparam int ADDR_W     = 15;
    localparam int MVAL_W     = 13;
    localparam int HI_W       = ADDR_W - MVAL_W;
    localparam int BA_W       = 2;
    localparam int MODE_REG_W = 32;
    localparam int EXT_LSB    = 16;
    localparam int PRE_BIT    = 10;
    localparam logic [MVAL_W-1:0] MODE_RST = MVAL_W'(13'h22);

    typedef enum logic [CODE_W-1:0] {
        OP_EMODE    = 4'd0,
        OP_MODE     = 4'd1,
        OP_PRE_ALL  = 4'd2,
        OP_REFRESH  = 4'd3,
        OP_SR_ENTER = 4'd4,
        OP_SR_EXIT  = 4'd5,
        OP_PD_ENTER = 4'd6,
        OP_PD_EXIT  = 4'd7
    } op_e;

    typedef struct packed {
        logic [RANKS-1:0]  cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic [RANKS-1:0]  cke;
    } pins_t;

    typedef struct packed {
        logic [MVAL_W-1:0] mval;
        logic [HI_W-1:0]   mhi;
        logic [MVAL_W-1:0] evalue;
        logic [HI_W-1:0]   ehi;
    } mode_t;
endpackage

// File: rtl/dci_mode_store.sv
`timescale 1ns/1ps
module dci_mode_store
    import dci_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_wr,
    input  logic [MODE_REG_W-1:0] mode_wdata,
    output mode_t                 mode_o
);
    localparam int MHI_LSB = MVAL_W;
    localparam int EHI_LSB = EXT_LSB + MVAL_W;

    mode_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d.mval   = mode_wdata[MVAL_W-1:0];
            st_d.mhi    = mode_wdata[MHI_LSB +: HI_W];
            st_d.evalue = mode_wdata[EXT_LSB +: MVAL_W];
            st_d.ehi    = mode_wdata[EHI_LSB +: HI_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mval: MODE_RST, mhi: '0, evalue: '0, ehi: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(st_q)); // R4
endmodule

// File: rtl/dci_pacer.sv
`timescale 1ns/1ps
module dci_pacer
    import dci_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [GAP_W-1:0]  gap,
    output logic              issue_o,
    output logic [WORD_W-1:0] issue_word_o,
    output logic              busy_o
);
    typedef struct packed {
        logic [GAP_W-1:0]  cnt;
        logic              pend_v;
        logic [WORD_W-1:0] pend;
    } pace_t;

    pace_t st_d, st_q;
    logic  legal_wr;
    logic  free;

    always_comb begin
        legal_wr     = cmd_wr && !cmd_word[CODE_W-1];
        free         = (st_q.cnt == '0);
        st_d         = st_q;
        issue_o      = 1'b0;
        issue_word_o = cmd_word;
        if (free && st_q.pend_v) begin
            issue_o      = 1'b1;
            issue_word_o = st_q.pend;
            st_d.pend_v  = legal_wr;
            st_d.pend    = cmd_word;
        end else if (free && legal_wr) begin
            issue_o      = 1'b1;
        end else if (legal_wr) begin
            st_d.pend_v  = 1'b1;
            st_d.pend    = cmd_word;
        end
        if (issue_o) begin
            st_d.cnt = gap;
        end else if (!free) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = !free;

    AST_GAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && gap != '0) |=> busy_o); // R11
    AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !issue_o); // R12
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_wr && !cmd_word[CODE_W-1]) |=> st_q.pend_v); // R12
    AST_DROP_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_word[CODE_W-1] && !st_q.pend_v && !busy_o) |-> !issue_o); // R13
endmodule

// File: rtl/dci_encoder.sv
`timescale 1ns/1ps
module dci_encoder
    import dci_pkg::*;
(
    input  logic              issue,
    input  logic [WORD_W-1:0] word,
    input  mode_t             mode,
    input  logic              fcram_en,
    input  pins_t             cur,
    output pins_t             nxt
);
    logic [RANKS-1:0] mask;
    op_e              op;

    always_comb begin
        mask      = word[WORD_W-1:CODE_W];
        op        = op_e'(word[CODE_W-1:0]);
        nxt       = cur;
        nxt.cs_n  = '1;
        nxt.ras_n = 1'b1;
        nxt.cas_n = 1'b1;
        nxt.we_n  = 1'b1;
        if (issue) begin
            case (op)
                OP_EMODE: begin
                    nxt.cs_n  = ~mask;
                    nxt.ras_n = 1'b0;
                    nxt.cas_n = 1'b0;
                    nxt.we_n  = 1'b0;
                    nxt.ba    = BA_W'(1);
                    nxt.addr  = {(fcram_en ? mode.ehi : HI_W'(0)), mode.evalue};
                end
                OP_MODE: begin
                    nxt.cs_n  = ~mask;
                    nxt.ras_n = 1'b0;
                    nxt.cas_n = 1'b0;
                    nxt.we_n  = 1'b0;
                    nxt.ba    = BA_W'(0);
                    nxt.addr  = {(fcram_en ? mode.mhi : HI_W'(0)), mode.mval};
                end
                OP_PRE_ALL: begin
                    nxt.cs_n  = ~mask;
                    nxt.ras_n = 1'b0;
                    nxt.we_n  = 1'b0;
                    nxt.addr  = ADDR_W'(1) << PRE_BIT;
                end
                OP_REFRESH: begin
                    nxt.cs_n  = ~mask;
                    nxt.ras_n = 1'b0;
                    nxt.cas_n = 1'b0;
                end
                OP_SR_ENTER: begin
                    nxt.cs_n  = ~mask;
                    nxt.ras_n = 1'b0;
                    nxt.cas_n = 1'b0;
                    nxt.cke   = cur.cke & ~mask;
                end
                OP_SR_EXIT, OP_PD_EXIT: nxt.cke = cur.cke | mask;
                OP_PD_ENTER:            nxt.cke = cur.cke & ~mask;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dram_cmd_issuer.sv
`timescale 1ns/1ps
module dram_cmd_issuer
    import dci_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_wr,
    input  logic [MODE_REG_W-1:0] mode_wdata,
    input  logic                  cmd_wr,
    input  logic [WORD_W-1:0]     cmd_word,
    input  logic                  fcram_en,
    input  logic [GAP_W-1:0]      gap_cycles,
    output logic [RANKS-1:0]      dram_cs_n,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    output logic                  dram_we_n,
    output logic [BA_W-1:0]       dram_ba,
    output logic [ADDR_W-1:0]     dram_addr,
    output logic [RANKS-1:0]      dram_cke,
    output logic                  busy
);
    mode_t             mode;
    logic              issue;
    logic [WORD_W-1:0] issue_word;
    pins_t             pins_d, pins_q, enc_nxt;

    dci_mode_store u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .mode_o     (mode)
    );

    dci_pacer #(.GAP_W(GAP_W)) u_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_word     (cmd_word),
        .gap          (gap_cycles),
        .issue_o      (issue),
        .issue_word_o (issue_word),
        .busy_o       (busy)
    );

    dci_encoder u_enc (
        .issue    (issue),
        .word     (issue_word),
        .mode     (mode),
        .fcram_en (fcram_en),
        .cur      (pins_q),
        .nxt      (enc_nxt)
    );

    always_comb begin
        pins_d = enc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '{cs_n: '1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                        ba: '0, addr: '0, cke: '1};
        end else begin
            pins_q <= pins_d;
        end
    end

    assign dram_cs_n  = pins_q.cs_n;
    assign dram_ras_n = pins_q.ras_n;
    assign dram_cas_n = pins_q.cas_n;
    assign dram_we_n  = pins_q.we_n;
    assign dram_ba    = pins_q.ba;
    assign dram_addr  = pins_q.addr;
    assign dram_cke   = pins_q.cke;

    AST_MODE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && !dram_cas_n && !dram_we_n) |-> (dram_ba[1] == 1'b0)); // R3
    AST_STD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && !dram_cas_n && !dram_we_n && !$past(fcram_en))
            |-> (dram_addr[ADDR_W-1:MVAL_W] == '0)); // R5
    AST_PRE_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && dram_cas_n && !dram_we_n)
            |-> (dram_addr == (ADDR_W'(1) << PRE_BIT))); // R6
    AST_REFRESH_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && !dram_cas_n && dram_we_n)
            |-> ((dram_cke & ~dram_cs_n) == '0 || $past(dram_cke) == dram_cke)); // R7
endmodule

// File: tb/dram_cmd_issuer_bench.sv
`timescale 1ns/1ps
module dram_cmd_issuer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [31:0] mode_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_word = '0;
    logic        fcram_en = 1'b0;
    logic [7:0]  gap_cycles = '0;
    logic [3:0]  dram_cs_n;
    logic        dram_ras_n, dram_cas_n, dram_we_n;
    logic [1:0]  dram_ba;
    logic [14:0] dram_addr;
    logic [3:0]  dram_cke;
    logic        busy;

    always #2.5 clk = ~clk;

    dram_cmd_issuer u_dram_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cmd_wr(cmd_wr), .cmd_word(cmd_word), .fcram_en(fcram_en),
        .gap_cycles(gap_cycles), .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_ba(dram_ba),
        .dram_addr(dram_addr), .dram_cke(dram_cke), .busy(busy)
    );

    typedef struct {
        int          due;
        bit          busy_only;
        bit          busy_v;
        logic [3:0]  cs_n;
        logic [2:0]  rcw;
        logic [1:0]  ba;
        logic [14:0] addr;
        logic [3:0]  cke;
        string       tag;
    } exp_t;

    exp_t  q[$];
    exp_t  cur_e;
    int    cyc = 0;
    int    errs = 0;
    int    checks = 0;
    bit    done = 0;
    string idle_tag = "R1";

    // reference model state
    logic [3:0]  m_cke = 4'hF;
    logic [1:0]  m_ba = 2'b00;
    logic [14:0] m_addr = '0;
    logic [12:0] m_mv = 13'h22, m_ev = '0;
    logic [1:0]  m_mh = '0, m_eh = '0;
    // last pattern seen by the monitor
    logic [3:0]  l_cke = 4'hF;
    logic [1:0]  l_ba = 2'b00;
    logic [14:0] l_addr = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, cyc, act, expv);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit hit;
            hit = 0;
            cyc++;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    cur_e = q[i];
                    q.delete(i);
                    if (cur_e.busy_only) begin
                        chk(busy == cur_e.busy_v, cur_e.tag, "busy", 32'(busy), 32'(cur_e.busy_v));
                    end else begin
                        hit = 1;
                        chk(dram_cs_n == cur_e.cs_n, cur_e.tag, "cs_n", 32'(dram_cs_n), 32'(cur_e.cs_n));
                        chk({dram_ras_n, dram_cas_n, dram_we_n} == cur_e.rcw, cur_e.tag, "ras/cas/we",
                            32'({dram_ras_n, dram_cas_n, dram_we_n}), 32'(cur_e.rcw));
                        chk(dram_ba == cur_e.ba, cur_e.tag, "ba", 32'(dram_ba), 32'(cur_e.ba));
                        chk(dram_addr == cur_e.addr, cur_e.tag, "addr", 32'(dram_addr), 32'(cur_e.addr));
                        chk(dram_cke == cur_e.cke, cur_e.tag, "cke", 32'(dram_cke), 32'(cur_e.cke));
                        l_cke = cur_e.cke; l_ba = cur_e.ba; l_addr = cur_e.addr;
                    end
                end
            end
            if (!hit) begin
                chk(dram_cs_n == 4'hF && {dram_ras_n, dram_cas_n, dram_we_n} == 3'b111, idle_tag,
                    "idle cmd lines", 32'({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}), 32'h7F);
                chk(dram_addr == l_addr && dram_ba == l_ba && dram_cke == l_cke, idle_tag,
                    "idle hold addr/ba/cke", 32'({dram_addr, dram_ba, dram_cke}),
                    32'({l_addr, l_ba, l_cke}));
            end
        end
    end

    function automatic exp_t build(input logic [3:0] code, input logic [3:0] mask, input string tag);
        exp_t e;
        e.busy_only = 0; e.busy_v = 0; e.tag = tag; e.due = 0;
        e.cs_n = 4'hF; e.rcw = 3'b111; e.ba = m_ba; e.addr = m_addr; e.cke = m_cke;
        case (code)
            4'd0: begin e.cs_n = ~mask; e.rcw = 3'b000; e.ba = 2'b01;
                        e.addr = {(fcram_en ? m_eh : 2'b00), m_ev}; end
            4'd1: begin e.cs_n = ~mask; e.rcw = 3'b000; e.ba = 2'b00;
                        e.addr = {(fcram_en ? m_mh : 2'b00), m_mv}; end
            4'd2: begin e.cs_n = ~mask; e.rcw = 3'b010; e.addr = 15'h0400; end
            4'd3: begin e.cs_n = ~mask; e.rcw = 3'b001; end
            4'd4: begin e.cs_n = ~mask; e.rcw = 3'b001; e.cke = m_cke & ~mask; end
            4'd5, 4'd7: e.cke = m_cke | mask;
            4'd6: e.cke = m_cke & ~mask;
            default: ;
        endcase
        return e;
    endfunction

    task automatic push_busy(input int at, input bit v, input string tag);
        exp_t e;
        e.due = at; e.busy_only = 1; e.busy_v = v; e.tag = tag;
        e.cs_n = '1; e.rcw = '1; e.ba = '0; e.addr = '0; e.cke = '0;
        q.push_back(e);
    endtask

    // lat: cycles from the write to the command cycle (0 = no command expected)
    // blen: busy window length to check from the command cycle (-1 = none)
    task automatic send(input logic [3:0] code, input logic [3:0] mask, input int lat,
                        input int blen, input string tag);
        exp_t e;
        int base;
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_word = {mask, code};
        if (lat > 0) begin
            e = build(code, mask, tag);
            e.due = cyc + lat;
            q.push_back(e);
            m_cke = e.cke; m_ba = e.ba; m_addr = e.addr;
        end
        if (blen >= 0) begin
            base = (lat > 0) ? cyc + lat : cyc + 1;
            for (int k = 0; k < blen; k++) push_busy(base + k, 1'b1, tag);
            push_busy(base + blen, 1'b0, tag);
        end
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen by idle checks and busy low
        push_busy(1, 1'b0, "R1");
        push_busy(2, 1'b0, "R1");
        repeat (3) @(negedge clk);
        idle_tag = "R10";

        // R4 reset mode value, R3 mode loads
        send(4'd1, 4'b0001, 1, 0, "R4");
        send(4'd0, 4'b1111, 1, -1, "R3");

        // R4 stored layout, R5 high address bits
        @(negedge clk);
        mode_wr = 1'b1;
        mode_wdata = {1'b0, 2'd1, 13'h00F3, 1'b0, 2'd2, 13'h01A5};
        m_mv = 13'h01A5; m_mh = 2'd2; m_ev = 13'h00F3; m_eh = 2'd1;
        fcram_en = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
        send(4'd1, 4'b0100, 1, -1, "R5");
        send(4'd0, 4'b1010, 1, -1, "R5");
        fcram_en = 1'b0;
        send(4'd1, 4'b0010, 1, -1, "R5");

        send(4'd2, 4'b0011, 1, -1, "R6");
        send(4'd3, 4'b1000, 1, -1, "R7");
        send(4'd4, 4'b0110, 1, -1, "R8");
        send(4'd5, 4'b0010, 1, -1, "R8");
        send(4'd6, 4'b1000, 1, -1, "R9");
        send(4'd7, 4'b1001, 1, -1, "R9");
        send(4'd3, 4'b0101, 1, -1, "R2");
        send(4'd2, 4'b0000, 1, -1, "R2");

        // R11 busy window
        gap_cycles = 8'd3;
        send(4'd3, 4'b0001, 1, 3, "R11");
        repeat (5) @(negedge clk);

        // R13 illegal codes
        send(4'hB, 4'b1111, 0, 0, "R13");
        send(4'hF, 4'b0110, 0, 0, "R13");
        repeat (3) @(negedge clk);

        // R12 held write, last one wins
        gap_cycles = 8'd5;
        send(4'd1, 4'b0001, 1, 5, "R12");
        send(4'd6, 4'b0100, 0, -1, "R12");
        send(4'd2, 4'b1000, 3, -1, "R12");
        repeat (10) @(negedge clk);

        gap_cycles = 8'd0;
        send(4'd3, 4'b1111, 1, 0, "R11");
        repeat (4) @(negedge clk);

        done = 1;
        chk(q.size() == 0, "R12", "pending expectations", 32'(q.size()), 32'd0);
        summary();
        $finish;
    end
endmodule